// File: doc/BRIEF.md
# Power-on reset hold with bus-pin escape

This block keeps a clock/calendar core in reset after power is applied, until a crystal oscillator has had enough time to start. On a tester that wait is too long. The block therefore also watches the levels of the two wire-bus pins, the data line (SDA) and the clock line (SCL). When it sees a timed toggle sequence on them, it releases the core reset at once and raises an override flag.

The override can only be entered if a software-writable enable bit is 1. That bit powers up as 1. Writing 0 to it drops the override, and the override cannot be entered again until a 1 is written. Apart from this, the bit does nothing.

While the core reset is active, the block also presents a per-register preset value and a preset mask. The mask marks which bits of each register take the preset and which keep their old contents.

Top module: `por_escape_ctl`

## Requirements
- R1: While `por_n` is low, `core_rst` is 1 and `ovr_active` is 0.
- R2: With no override, `core_rst` falls OSC_US×CLK_PER_US sample clocks after `por_n` rises, give or take the few cycles spent in the two-flop release stage, and it stays low after that.
- R3: The toggle sequence is ignored until BLANK_US×CLK_PER_US sample clocks have passed since `por_n` rose.
- R4: The sequence is recognised only in this order, and completing it sets `ovr_active`:
  1. Both pins are low.
  2. SCL goes high and stays high for at least ceil(PULSE_NS×CLK_PER_US/1000) clocks.
  3. SCL falls, and SDA then stays low for at least ceil(HOLD_NS×CLK_PER_US/1000) clocks.
  4. SDA rises.
- R5: A high or hold phase shorter than its minimum, or an edge out of order, leaves `ovr_active` at 0. An example of an out-of-order edge is SDA rising while SCL is high.
- R6: Both pins pass through two synchronising flops. `ovr_active` rises, and `core_rst` falls in the same cycle, on the third clock edge after SDA rises at the pin.
- R7: A write (`testc_wr`=1) with `testc_din`=0 clears `ovr_active` on the next edge. After that, `core_rst` follows the start-up timer alone.
- R8: The enable bit is 1 after power-on. While it is 0, the sequence is not recognised. Writing 1 makes the sequence recognisable again.
- R9: While `ovr_active` is 0, writing 0 to the enable bit does not change `core_rst`.
- R10: Register k owns bits [8k+7:8k] of both `preset_val` and `preset_mask`. The presets are:
  - Register 0: mask FFh, value 08h.
  - Register 1: mask FFh, value 00h.
  - Registers 2, 9, 10, 11 and 12: mask 80h, value 80h.
  - Register 13: mask 83h, value 80h.
  - Register 14: mask 83h, value 03h.
  - Every other register: mask 00h, value 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| por_n | input | 1 | Raw power-on indication, low while power is not good |
| sda_pin | input | 1 | Data pin level, asynchronous |
| scl_pin | input | 1 | Clock pin level, asynchronous |
| testc_wr | input | 1 | Write strobe for the enable bit |
| testc_din | input | 1 | Value written to the enable bit |
| core_rst | output | 1 | Reset to the core, active high |
| ovr_active | output | 1 | The escape sequence has been accepted |
| preset_val | output | NUM_REGS×8 | Preset value per register |
| preset_mask | output | NUM_REGS×8 | Which preset bits are applied |

## Verification
The table of sequences varies the width of the SCL high pulse and the width of the SDA hold, each exactly at its minimum, one clock below it, and well above it. This separates a correct length comparison from an off-by-one error. Directed sequences check three more cases:
- A sequence that completes inside the blanking window.
- A sequence with SDA rising while SCL is high, which tests the ordering.
- A sequence sent while the enable bit is 0.

Early release is timed to the exact edge, and the plain start-up timeout is checked against a window. Clearing the enable bit is tried both during an override and in normal operation, to show that a clear drops the override but has no other effect.

// File: rtl/por_escape_pkg.sv
package por_escape_pkg;

   typedef enum logic [1:0] {
      PD_IDLE  = 2'd0,
      PD_ARMED = 2'd1,
      PD_CLKHI = 2'd2,
      PD_HOLD  = 2'd3
   } pd_state_e;

   localparam int BYTE_W = 8;

   function automatic logic [7:0] preset_mask_of(input int idx);
      case (idx)
         0, 1:              return 8'hFF;
         2, 9, 10, 11, 12:  return 8'h80;
         13, 14:            return 8'h83;
         default:           return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] preset_val_of(input int idx);
      case (idx)
         0:                 return 8'h08;
         2, 9, 10, 11, 12:  return 8'h80;
         13:                return 8'h80;
         14:                return 8'h03;
         default:           return 8'h00;
      endcase
   endfunction

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/por_sync2.sv
module por_sync2 #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic [1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 2'b11;
            else        stage_q <= {stage_q[0], din[gi]};
         end
         assign dout[gi] = stage_q[1];
      end
   endgenerate
endmodule

// File: rtl/por_age_timer.sv
module por_age_timer #(
   parameter int BLANK_CNT = 32000,
   parameter int OSC_CNT   = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   output logic blank_done,
   output logic osc_done
);
   localparam int TOP_CNT = (BLANK_CNT > OSC_CNT) ? BLANK_CNT : OSC_CNT;
   localparam int AW      = $clog2(TOP_CNT + 1);
   localparam logic [AW-1:0] TOP_V   = AW'(TOP_CNT);
   localparam logic [AW-1:0] BLANK_V = AW'(BLANK_CNT);
   localparam logic [AW-1:0] OSC_V   = AW'(OSC_CNT);

   logic [AW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != TOP_V) age_q <= age_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_done <= 1'b0;
         osc_done   <= 1'b0;
      end else begin
         if (age_q >= BLANK_V) blank_done <= 1'b1;
         if (age_q >= OSC_V)   osc_done   <= 1'b1;
      end
   end
endmodule

// File: rtl/por_pattern_fsm.sv
module por_pattern_fsm
   import por_escape_pkg::*;
#(
   parameter int PULSE_CNT = 2,
   parameter int HOLD_CNT  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sda,
   input  logic scl,
   output logic hit
);
   localparam int MAXC = (PULSE_CNT > HOLD_CNT) ? PULSE_CNT : HOLD_CNT;
   localparam int CW   = $clog2(MAXC + 2);
   localparam logic [CW-1:0] CSAT    = CW'(MAXC + 1);
   localparam logic [CW-1:0] PULSE_V = CW'(PULSE_CNT);
   localparam logic [CW-1:0] HOLD_V  = CW'(HOLD_CNT);

   pd_state_e     st_q, st_n;
   logic [CW-1:0] cnt_q, cnt_n, cnt_inc;

   assign cnt_inc = (cnt_q == CSAT) ? cnt_q : cnt_q + 1'b1;

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_inc;
      hit   = 1'b0;
      if (!armed) begin
         st_n = PD_IDLE;
      end else begin
         unique case (st_q)
            PD_IDLE:  if (!sda && !scl) st_n = PD_ARMED;
            PD_ARMED: begin
               if (sda)      st_n = PD_IDLE;
               else if (scl) begin
                  st_n  = PD_CLKHI;
                  cnt_n = CW'(1);
               end
            end
            PD_CLKHI: begin
               if (sda) st_n = PD_IDLE;
               else if (!scl) begin
                  if (cnt_q >= PULSE_V) begin
                     st_n  = PD_HOLD;
                     cnt_n = CW'(1);
                  end else begin
                     st_n = PD_IDLE;
                  end
               end
            end
            PD_HOLD: begin
               if (scl) st_n = PD_IDLE;
               else if (sda) begin
                  st_n = PD_IDLE;
                  hit  = (cnt_q >= HOLD_V);
               end
            end
            default: st_n = PD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PD_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
      end
   end
endmodule

// File: rtl/por_preset_table.sv
module por_preset_table
   import por_escape_pkg::*;
#(
   parameter int NUM_REGS = 16
) (
   output logic [NUM_REGS*BYTE_W-1:0] val,
   output logic [NUM_REGS*BYTE_W-1:0] mask
);
   genvar gr;
   generate
      for (gr = 0; gr < NUM_REGS; gr++) begin : g_reg
         assign val [gr*BYTE_W +: BYTE_W] = preset_val_of(gr);
         assign mask[gr*BYTE_W +: BYTE_W] = preset_mask_of(gr);
      end
   endgenerate
endmodule

// File: rtl/por_escape_ctl.sv
module por_escape_ctl
   import por_escape_pkg::*;
#(
   parameter int CLK_PER_US = 4,
   parameter int BLANK_US   = 8000,
   parameter int OSC_US     = 500000,
   parameter int PULSE_NS   = 500,
   parameter int HOLD_NS    = 2000,
   parameter int NUM_REGS   = 16
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  sda_pin,
   input  logic                  scl_pin,
   input  logic                  testc_wr,
   input  logic                  testc_din,
   output logic                  core_rst,
   output logic                  ovr_active,
   output logic [NUM_REGS*8-1:0] preset_val,
   output logic [NUM_REGS*8-1:0] preset_mask
);
   localparam int BLANK_CNT = BLANK_US * CLK_PER_US;
   localparam int OSC_CNT   = OSC_US * CLK_PER_US;
   localparam int PULSE_CNT = ceil_div(PULSE_NS * CLK_PER_US, 1000);
   localparam int HOLD_CNT  = ceil_div(HOLD_NS * CLK_PER_US, 1000);

   generate
      if (CLK_PER_US < 1)   begin : g_bad_rate  $error("CLK_PER_US must be at least 1"); end
      if (PULSE_CNT < 1)    begin : g_bad_pulse $error("pulse minimum rounds to zero");  end
      if (OSC_CNT < 1)      begin : g_bad_osc   $error("start-up count must be nonzero"); end
      if (NUM_REGS < 15)    begin : g_bad_regs  $error("NUM_REGS must cover the preset registers"); end
   endgenerate

   logic [1:0] por_q;
   logic       rst_n;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) por_q <= 2'b00;
      else        por_q <= {por_q[0], 1'b1};
   end
   assign rst_n = por_q[1];

   logic [1:0] pins_s;
   por_sync2 #(.WIDTH(2)) u_pins (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_pin, sda_pin}),
      .dout (pins_s)
   );

   logic blank_done, osc_done;
   por_age_timer #(.BLANK_CNT(BLANK_CNT), .OSC_CNT(OSC_CNT)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .blank_done(blank_done),
      .osc_done  (osc_done)
   );

   logic testc_q, ovr_q, armed, hit;
   assign armed = blank_done && testc_q && !ovr_q;

   por_pattern_fsm #(.PULSE_CNT(PULSE_CNT), .HOLD_CNT(HOLD_CNT)) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .armed(armed),
      .sda  (pins_s[0]),
      .scl  (pins_s[1]),
      .hit  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         testc_q <= 1'b1;
         ovr_q   <= 1'b0;
      end else begin
         if (testc_wr) testc_q <= testc_din;
         if (testc_wr && !testc_din) ovr_q <= 1'b0;
         else if (hit)               ovr_q <= 1'b1;
      end
   end

   assign ovr_active = ovr_q;
   assign core_rst   = !rst_n || (!osc_done && !ovr_q);

   por_preset_table #(.NUM_REGS(NUM_REGS)) u_tbl (
      .val (preset_val),
      .mask(preset_mask)
   );
endmodule

// File: rtl/por_escape_ctl_chk.sv
module por_escape_ctl_chk (
   input logic clk,
   input logic por_n,
   input logic rst_n,
   input logic testc_wr,
   input logic testc_din,
   input logic testc_q,
   input logic blank_done,
   input logic core_rst,
   input logic ovr_active
);
   a_r1_por_holds: assert property (@(posedge clk)
      !por_n |-> (core_rst && !ovr_active));

   a_r3_no_entry_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_active) |-> blank_done);

   a_r8_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_active) |-> $past(testc_q));

   a_r7_clear_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (testc_wr && !testc_din) |=> !ovr_active);

   a_r6_release_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_active |-> !core_rst);

   a_r9_zero_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (testc_wr && !testc_din && !core_rst && !ovr_active) |=> !core_rst);
endmodule

bind por_escape_ctl por_escape_ctl_chk u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .testc_wr  (testc_wr),
   .testc_din (testc_din),
   .testc_q   (testc_q),
   .blank_done(blank_done),
   .core_rst  (core_rst),
   .ovr_active(ovr_active)
);

// File: tb/por_escape_ctl_bench.sv
module por_escape_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RATE  = 4;
   localparam int BLANK = 20;
   localparam int OSC   = 100;
   localparam int OSC_CLKS   = OSC * RATE;
   localparam int NREG = 16;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sda = 1'b1, scl = 1'b0;
   logic twr = 1'b0, tdin = 1'b0;
   logic core_rst, ovr;
   logic [NREG*8-1:0] pval, pmask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   por_escape_ctl #(
      .CLK_PER_US(RATE), .BLANK_US(BLANK), .OSC_US(OSC),
      .PULSE_NS(500), .HOLD_NS(2000), .NUM_REGS(NREG)
   ) u_por_escape_ctl (
      .clk(clk), .por_n(por_n), .sda_pin(sda), .scl_pin(scl),
      .testc_wr(twr), .testc_din(tdin), .core_rst(core_rst),
      .ovr_active(ovr), .preset_val(pval), .preset_mask(pmask)
   );

   // {high width, hold width, expected override}; minimums are 2 and 8 clocks
   localparam logic [16:0] VEC [6] = '{
      {8'd2, 8'd8,  1'b1},
      {8'd1, 8'd8,  1'b0},
      {8'd2, 8'd7,  1'b0},
      {8'd5, 8'd20, 1'b1},
      {8'd3, 8'd8,  1'b1},
      {8'd2, 8'd2,  1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic power_cycle();
      @(negedge clk); por_n = 1'b0; sda = 1'b1; scl = 1'b0;
      tick(3);
      por_n = 1'b1;
   endtask

   task automatic write_en(input logic v);
      @(negedge clk); twr = 1'b1; tdin = v;
      @(negedge clk); twr = 1'b0;
   endtask

   // drives the sequence and leaves SDA just raised
   task automatic drive_seq(input int hi, input int hold);
      @(negedge clk); sda = 1'b0; scl = 1'b0;
      tick(3); scl = 1'b1;
      tick(hi); scl = 1'b0;
      tick(hold); sda = 1'b1;
   endtask

   initial begin
      // R1 reset state
      tick(2);
      chk("R1 core_rst during power-off", 32'(core_rst), 32'd1);
      chk("R1 ovr during power-off", 32'(ovr), 32'd0);
      // R10 presets
      chk("R10 reg0 val", 32'(pval[7:0]), 32'h08);
      chk("R10 reg0 mask", 32'(pmask[7:0]), 32'hFF);
      chk("R10 reg1 val", 32'(pval[15:8]), 32'h00);
      chk("R10 reg2 mask", 32'(pmask[23:16]), 32'h80);
      chk("R10 reg3 mask", 32'(pmask[31:24]), 32'h00);
      chk("R10 reg12 val", 32'(pval[103:96]), 32'h80);
      chk("R10 reg13 val/mask", {16'd0, pval[111:104], pmask[111:104]}, 32'h8083);
      chk("R10 reg14 val/mask", {16'd0, pval[119:112], pmask[119:112]}, 32'h0383);

      // R3 sequence inside blanking window
      power_cycle();
      tick(5);
      drive_seq(2, 8); tick(5);
      chk("R3 ovr in blank window", 32'(ovr), 32'd0);
      chk("R3 core_rst in blank window", 32'(core_rst), 32'd1);

      // R6 early release timing, R8 enable powers up 1
      power_cycle();
      tick(100);
      drive_seq(2, 8);
      tick(2);
      chk("R6 core_rst two edges after SDA rise", 32'(core_rst), 32'd1);
      tick(1);
      chk("R6 core_rst third edge", 32'(core_rst), 32'd0);
      chk("R8 ovr set with enable from power-up", 32'(ovr), 32'd1);

      // R7 clear before start-up expiry: reset returns
      write_en(1'b0);
      chk("R7 ovr cleared", 32'(ovr), 32'd0);
      chk("R7 core_rst follows timer", 32'(core_rst), 32'd1);
      write_en(1'b1);

      // R4/R5 table walk
      for (int i = 0; i < 6; i++) begin
         write_en(1'b0);
         write_en(1'b1);
         drive_seq(int'(VEC[i][16:9]), int'(VEC[i][8:1]));
         tick(4);
         chk($sformatf("R4 R5 vector %0d", i), 32'(ovr), 32'(VEC[i][0]));
      end

      // R5 order: SDA rises while SCL high
      write_en(1'b0); write_en(1'b1);
      @(negedge clk); sda = 1'b0; scl = 1'b0;
      tick(3); scl = 1'b1;
      tick(3); sda = 1'b1;
      tick(3); scl = 1'b0;
      tick(10);
      chk("R5 out-of-order edge", 32'(ovr), 32'd0);

      // R2 plain start-up timeout
      power_cycle();
      tick(OSC_CLKS - 5);
      chk("R2 reset held before timeout", 32'(core_rst), 32'd1);
      tick(10);
      chk("R2 reset released after timeout", 32'(core_rst), 32'd0);

      // R9 writing 0 in normal operation
      write_en(1'b0);
      tick(2);
      chk("R9 core_rst unchanged by enable=0", 32'(core_rst), 32'd0);
      // R8 blocked while 0, re-armed by 1
      drive_seq(2, 8); tick(5);
      chk("R8 blocked while enable=0", 32'(ovr), 32'd0);
      write_en(1'b1);
      drive_seq(2, 8); tick(5);
      chk("R8 re-armed by enable=1", 32'(ovr), 32'd1);
      write_en(1'b0);
      chk("R7 clear after timeout", 32'(ovr), 32'd0);
      chk("R7 core_rst stays low after timeout", 32'(core_rst), 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule